// File: doc/BRIEF.md
# Quick Access Halt-Execute-Resume Sequencer

This block carries out one debugger command. It briefly stops a running hart, runs the instruction buffer once, and then lets the hart continue. A command word arrives on a valid/ready port. The block then works through three request/acknowledge channels in a fixed order: halt control, buffer executor and resume control. It reports `busy` while a command is open, a one-cycle `done` pulse when the command ends, and an error code that stays visible until the next command of this type is accepted. The block has no path to the data argument registers, so it can never change them.

Command port rules: `cmd_ready` is high only while the block is idle. A command is taken on any cycle where `cmd_valid` and `cmd_ready` are both high. A sender that finds `cmd_ready` low has to hold its word and wait. Type value 1 starts a sequence. Any other type is taken and dropped, and it has no effect.

The halt acknowledge carries a cause value. Only the cause equal to `REQ_CAUSE` counts as the halt that this block asked for. Any other cause means the hart stopped for some reason of its own, such as a breakpoint. Error codes are 0 for none, 3 for exception and 4 for halt/resume.

Top module: `qa_sequencer`

## Requirements
- R1: After reset, `busy` and `done` are 0, `cmd_ready` is 1, all three request outputs are 0, and `cmd_err` is 0.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only when the block is idle. Type 1 starts a sequence. Any other type is consumed and leaves `busy`, the requests and `cmd_err` unchanged.
- R3: If `hart_halted` is high when a type-1 command is accepted, no halt request is raised. In the next cycle `done` pulses and `cmd_err` reads 4.
- R4: Otherwise `halt_req` rises in the cycle after acceptance and stays high until a cycle with `halt_ack` high.
- R5: A halt acknowledge whose `halt_cause` equals `REQ_CAUSE` (default 3) raises `exec_req` in the next cycle. Any other cause sets `cmd_err` to 4 and pulses `done` in the next cycle, with no execute request and no resume request.
- R6: `exec_req` stays high until `exec_ack`. If `exec_exc` is high in the acknowledge cycle, `cmd_err` becomes 3.
- R7: After the execute acknowledge, whether or not it reports an exception, `resume_req` rises in the next cycle and stays high until `resume_ack`. `done` then pulses in the following cycle.
- R8: At most one request output is high at any time. An acknowledge on a channel whose request is low has no effect.
- R9: `cmd_err` is cleared when a type-1 command is accepted on a hart that is not halted. It changes at no other time except the error events in R3, R5 and R6.
- R10: `busy` is high from the cycle after a type-1 acceptance through the cycle in which `done` pulses, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can take a command (idle) |
| cmd_type | input | TYPE_W | Command type; 1 selects this sequence |
| hart_halted | input | 1 | Hart is currently halted |
| halt_req | output | 1 | Request to halt the hart |
| halt_ack | input | 1 | Hart has halted |
| halt_cause | input | CAUSE_W | Reason for the halt, valid with `halt_ack` |
| exec_req | output | 1 | Request to run the instruction buffer once |
| exec_ack | input | 1 | Buffer run finished |
| exec_exc | input | 1 | Buffer run ended on an exception, valid with `exec_ack` |
| resume_req | output | 1 | Request to resume the hart |
| resume_ack | input | 1 | Hart has resumed |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when the command ends |
| cmd_err | output | 3 | 0 none, 3 exception, 4 halt/resume |

## Verification
Two events can arrive in the same cycle: the executor reports an exception, and it reports that the buffer run is over. Both come on one edge, `exec_ack` together with `exec_exc`. The bench drives both in one cycle and checks two things in the next cycle: `cmd_err` reads 3 and `resume_req` is high. It then confirms that the sequence still ends with a `done` pulse, and that the next accepted command clears the error.

// File: rtl/qa_pkg.sv
package qa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HALT   = 3'd1,
    ST_EXEC   = 3'd2,
    ST_RESUME = 3'd3,
    ST_FINISH = 3'd4
  } qa_state_e;

  typedef enum logic [2:0] {
    QERR_NONE  = 3'd0,
    QERR_EXC   = 3'd3,
    QERR_HALTR = 3'd4
  } qa_err_e;

  localparam int CH_HALT = 0;
  localparam int CH_EXEC = 1;
  localparam int CH_RES  = 2;
  localparam int NUM_CH  = 3;

  function automatic qa_state_e chan_state(input int c);
    case (c)
      CH_HALT: return ST_HALT;
      CH_EXEC: return ST_EXEC;
      default: return ST_RESUME;
    endcase
  endfunction

endpackage

// File: rtl/qa_cause_match.sv
module qa_cause_match #(
  parameter int CAUSE_W   = 3,
  parameter int REQ_CAUSE = 3
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               requested_o
);
  localparam logic [CAUSE_W-1:0] REQ_VAL = CAUSE_W'(REQ_CAUSE);

  assign requested_o = (cause_i == REQ_VAL);
endmodule

// File: rtl/qa_err_reg.sv
module qa_err_reg
  import qa_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr_i,
  input  logic    set_haltr_i,
  input  logic    set_exc_i,
  output qa_err_e err_o
);
  qa_err_e err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_q <= QERR_NONE;
    else if (set_haltr_i) err_q <= QERR_HALTR;
    else if (set_exc_i)   err_q <= QERR_EXC;
    else if (clr_i)       err_q <= QERR_NONE;
  end

  assign err_o = err_q;

  AST_ERR_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_haltr_i && set_exc_i)) else $error("two error sets at once"); // R9
endmodule

// File: rtl/qa_fsm.sv
module qa_fsm
  import qa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              halted_i,
  input  logic              halt_ack_i,
  input  logic              cause_ok_i,
  input  logic              exec_ack_i,
  input  logic              exec_exc_i,
  input  logic              resume_ack_i,
  output logic [NUM_CH-1:0] req_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              clr_err_o,
  output logic              set_haltr_o,
  output logic              set_exc_o
);
  qa_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    clr_err_o   = 1'b0;
    set_haltr_o = 1'b0;
    set_exc_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (halted_i) begin
            set_haltr_o = 1'b1;
            state_d     = ST_FINISH;
          end else begin
            clr_err_o = 1'b1;
            state_d   = ST_HALT;
          end
        end
      end
      ST_HALT: begin
        if (halt_ack_i) begin
          if (cause_ok_i) begin
            state_d = ST_EXEC;
          end else begin
            set_haltr_o = 1'b1;
            state_d     = ST_FINISH;
          end
        end
      end
      ST_EXEC: begin
        if (exec_ack_i) begin
          set_exc_o = exec_exc_i;
          state_d   = ST_RESUME;
        end
      end
      ST_RESUME: begin
        if (resume_ack_i) state_d = ST_FINISH;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    assign req_o[c] = (state_q == chan_state(c));
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = (state_q == ST_FINISH);

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_o)) else $error("several requests"); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[CH_HALT] && !halt_ack_i |=> req_o[CH_HALT]) else $error("halt req dropped"); // R4
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[CH_EXEC] && !exec_ack_i |=> req_o[CH_EXEC]) else $error("exec req dropped"); // R6
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[CH_RES] && !resume_ack_i |=> req_o[CH_RES]) else $error("resume req dropped"); // R7
  AST_RES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[CH_RES] && resume_ack_i |=> done_o && busy_o) else $error("no done after resume"); // R7
endmodule

// File: rtl/qa_sequencer.sv
module qa_sequencer
  import qa_pkg::*;
#(
  parameter int TYPE_W    = 8,
  parameter int QA_TYPE   = 1,
  parameter int CAUSE_W   = 3,
  parameter int REQ_CAUSE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [TYPE_W-1:0]  cmd_type,
  input  logic               hart_halted,
  output logic               halt_req,
  input  logic               halt_ack,
  input  logic [CAUSE_W-1:0] halt_cause,
  output logic               exec_req,
  input  logic               exec_ack,
  input  logic               exec_exc,
  output logic               resume_req,
  input  logic               resume_ack,
  output logic               busy,
  output logic               done,
  output logic [2:0]         cmd_err
);
  localparam logic [TYPE_W-1:0] QA_TYPE_VAL = TYPE_W'(QA_TYPE);

  logic              start;
  logic              cause_ok;
  logic [NUM_CH-1:0] req;
  logic              clr_err, set_haltr, set_exc;
  qa_err_e           err;

  assign start = cmd_valid && cmd_ready && (cmd_type == QA_TYPE_VAL);

  qa_cause_match #(.CAUSE_W(CAUSE_W), .REQ_CAUSE(REQ_CAUSE)) u_cause (
    .cause_i     (halt_cause),
    .requested_o (cause_ok)
  );

  qa_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .halted_i     (hart_halted),
    .halt_ack_i   (halt_ack),
    .cause_ok_i   (cause_ok),
    .exec_ack_i   (exec_ack),
    .exec_exc_i   (exec_exc),
    .resume_ack_i (resume_ack),
    .req_o        (req),
    .busy_o       (busy),
    .ready_o      (cmd_ready),
    .done_o       (done),
    .clr_err_o    (clr_err),
    .set_haltr_o  (set_haltr),
    .set_exc_o    (set_exc)
  );

  qa_err_reg u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_err),
    .set_haltr_i (set_haltr),
    .set_exc_i   (set_exc),
    .err_o       (err)
  );

  assign halt_req   = req[CH_HALT];
  assign exec_req   = req[CH_EXEC];
  assign resume_req = req[CH_RES];
  assign cmd_err    = err;

  AST_HALTED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    start && hart_halted |=> done && !halt_req && cmd_err == 3'd4) else $error("halted start"); // R3
  AST_FOREIGN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && halt_ack && !cause_ok |=> done && !exec_req && cmd_err == 3'd4) else $error("foreign halt"); // R5
  AST_EXC_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req && exec_ack && exec_exc |=> resume_req && cmd_err == 3'd3) else $error("exception path"); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(cmd_err)) else $error("error moved while idle"); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !cmd_ready && busy) else $error("ready after start"); // R10
endmodule

// File: tb/tb_qa_sequencer.sv
module tb_qa_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_type = '0;
  logic       hart_halted = 1'b0;
  logic       halt_req, halt_ack = 1'b0;
  logic [2:0] halt_cause = '0;
  logic       exec_req, exec_ack = 1'b0, exec_exc = 1'b0;
  logic       resume_req, resume_ack = 1'b0;
  logic       busy, done;
  logic [2:0] cmd_err;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  qa_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .hart_halted(hart_halted), .halt_req(halt_req),
    .halt_ack(halt_ack), .halt_cause(halt_cause), .exec_req(exec_req),
    .exec_ack(exec_ack), .exec_exc(exec_exc), .resume_req(resume_req),
    .resume_ack(resume_ack), .busy(busy), .done(done), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] t);
    @(negedge clk); cmd_valid = 1'b1; cmd_type = t;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic ack_halt(input logic [2:0] cause);
    @(negedge clk); halt_ack = 1'b1; halt_cause = cause;
    @(negedge clk); halt_ack = 1'b0;
  endtask

  task automatic ack_exec(input logic exc);
    @(negedge clk); exec_ack = 1'b1; exec_exc = exc;
    @(negedge clk); exec_ack = 1'b0; exec_exc = 1'b0;
  endtask

  task automatic ack_resume();
    @(negedge clk); resume_ack = 1'b1;
    @(negedge clk); resume_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "ready", cmd_ready, 1);
    chk("R1", "reqs", {halt_req, exec_req, resume_req}, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", cmd_err, 0);
  endtask

  task automatic t_normal();
    send_cmd(8'd1);
    chk("R4", "halt_req", halt_req, 1);
    chk("R10", "busy", busy, 1);
    chk("R2", "ready while busy", cmd_ready, 0);
    repeat (3) @(negedge clk);
    chk("R4", "halt_req held", halt_req, 1);
    ack_halt(3'd3);
    chk("R5", "exec_req", exec_req, 1);
    chk("R8", "halt_req dropped", halt_req, 0);
    repeat (2) @(negedge clk);
    chk("R6", "exec_req held", exec_req, 1);
    ack_exec(1'b0);
    chk("R7", "resume_req", resume_req, 1);
    chk("R6", "no error", cmd_err, 0);
    ack_resume();
    chk("R7", "done", done, 1);
    chk("R10", "busy in done", busy, 1);
    @(negedge clk);
    chk("R10", "idle", busy, 0);
    chk("R7", "done one cycle", done, 0);
  endtask

  task automatic t_already_halted();
    hart_halted = 1'b1;
    send_cmd(8'd1);
    chk("R3", "done", done, 1);
    chk("R3", "no halt_req", halt_req, 0);
    chk("R3", "err", cmd_err, 4);
    hart_halted = 1'b0;
    @(negedge clk);
    chk("R10", "idle after", busy, 0);
  endtask

  task automatic t_foreign_halt();
    send_cmd(8'd1);
    chk("R9", "err cleared on start", cmd_err, 0);
    ack_halt(3'd1);
    chk("R5", "done", done, 1);
    chk("R5", "err", cmd_err, 4);
    chk("R5", "no exec/resume", {exec_req, resume_req}, 0);
    @(negedge clk);
  endtask

  task automatic t_exception();
    send_cmd(8'd1);
    ack_halt(3'd3);
    ack_exec(1'b1);
    chk("R6", "err exc", cmd_err, 3);
    chk("R7", "resume after exc", resume_req, 1);
    ack_resume();
    chk("R7", "done after exc", done, 1);
    chk("R6", "err kept", cmd_err, 3);
    @(negedge clk);
  endtask

  task automatic t_other_type();
    send_cmd(8'd2);
    chk("R2", "busy other type", busy, 0);
    chk("R2", "reqs other type", {halt_req, exec_req, resume_req}, 0);
    chk("R2", "err other type", cmd_err, 3);
    chk("R2", "ready other type", cmd_ready, 1);
  endtask

  task automatic t_stray_acks();
    ack_exec(1'b1);
    ack_resume();
    ack_halt(3'd3);
    chk("R8", "idle stray busy", busy, 0);
    chk("R8", "idle stray reqs", {halt_req, exec_req, resume_req}, 0);
    chk("R9", "idle stray err", cmd_err, 3);
    send_cmd(8'd1);
    chk("R9", "err cleared", cmd_err, 0);
    ack_exec(1'b1);
    ack_resume();
    chk("R8", "halt_req kept", halt_req, 1);
    chk("R8", "stray exec no err", cmd_err, 0);
    ack_halt(3'd3);
    ack_resume();
    chk("R8", "exec_req kept", exec_req, 1);
    ack_exec(1'b0);
    ack_resume();
    chk("R7", "done", done, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_already_halted();
    t_foreign_halt();
    t_exception();
    t_other_type();
    t_stray_acks();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule